// File: doc/BRIEF.md
# Debug Halt Control and Status Register

This block is a single 32-bit control and status word on a small debug-side register bus. A debugger uses it to enable halting debug, to stop and restart a core, to step the core one instruction at a time and to mask interrupts while the core is stopped. The same word reports live core conditions: halted, sleeping, locked up and core-register transfer ready. It also holds three sticky event flags that clear when the word is read.

Control writes are protected by a 16-bit key carried in the upper half of the write data. A write without the key leaves every control bit as it was. Writes that come from the core side rather than the debug port can change every control bit except the debug enable. A small sequencer releases a halted core for exactly one instruction when a step is requested. It raises the halt request again in the same cycle the instruction retires.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: A write to the register address changes bits [3:0] only when write data bits [31:16] equal the key parameter (default 0xA05F); with any other upper halfword the control bits keep their values.
- R2: The read word carries control bits at bit 0 (debug enable), bit 1 (halt), bit 2 (step) and bit 3 (interrupt mask), and live status at bit 16 (transfer ready), bit 17 (halted), bit 18 (sleeping) and bit 19 (locked up); bits [15:4], [23:20] and [31:27] read 0 and the key is never returned.
- R3: Bit 24 (instruction retired), bit 25 (core reset seen) and bit 26 (core left halted state) are set by their events and cleared by a read of the register; an event in the same cycle as the read sets the bit again after that read.
- R4: The locked-up bit is set by the lockup input and cleared to 0 once the core reports halted.
- R5: The transfer-ready bit clears to 0 on a transfer-start pulse and sets to 1 on a transfer-done pulse.
- R6: The power-on reset clears the whole register; a core reset pulse clears the halt bit but leaves the debug enable bit unchanged.
- R7: A keyed write with step 1, halt 0 and debug enable 1 while the core is halted releases it for exactly one retired instruction, after which the halt bit reads 1 and the core halts again.
- R8: A keyed write marked as coming from the core side does not change the debug enable bit.
- R9: While debug enable is 0, the halt request and step request outputs stay 0 whatever the halt and step bits hold.
- R10: The interrupt mask bit takes the written value only when the halt bit was already 1 and the same write sets halt to 1; otherwise the mask keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| addr_i | input | ADDR_W | Register bus address |
| wdata_i | input | 32 | Register bus write data |
| we_i | input | 1 | Write enable |
| re_i | input | 1 | Read enable; a read at the register address clears the sticky bits |
| src_core_i | input | 1 | Marks the current write as coming from the core side |
| rdata_o | output | 32 | Read data, valid in the cycle of re_i, 0 otherwise |
| halt_req_o | output | 1 | Request to the core to enter or stay in the halted state |
| step_req_o | output | 1 | Core is released for a single instruction |
| halted_i | input | 1 | Core is in the halted state |
| retire_i | input | 1 | Pulse per retired instruction |
| core_reset_i | input | 1 | Pulse when the core is reset |
| lockup_i | input | 1 | Core has locked up |
| sleeping_i | input | 1 | Core is sleeping |
| xfer_start_i | input | 1 | Core-register transfer started |
| xfer_done_i | input | 1 | Core-register transfer finished |

## Verification
A corrupted control bit shows in the read word on the next read and in the halt request output in the same cycle. A fault in the step sequencer shows as a retire count other than one between the step write and the core halting again, within a few cycles of the write. A sticky flag that clears at the wrong time, or that loses an event arriving during a read, shows on the next read as a missing or extra bit. A wrong mask or key decision shows after one write and one read, and the bench sweeps every pair of consecutive control values to reach it.

// File: rtl/dhcs_pkg.sv
package dhcs_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned KEY_LSB = 16;
  localparam int unsigned KEY_W   = DATA_W - KEY_LSB;
  localparam int unsigned CTRL_W  = 4;
  localparam int unsigned N_STICKY = 3;

  localparam int unsigned B_EN    = 0;
  localparam int unsigned B_HALT  = 1;
  localparam int unsigned B_STEP  = 2;
  localparam int unsigned B_MASK  = 3;
  localparam int unsigned B_RDY   = 16;
  localparam int unsigned B_HLTD  = 17;
  localparam int unsigned B_SLP   = 18;
  localparam int unsigned B_LOCK  = 19;
  localparam int unsigned B_STICKY = 24;  // retired, reset seen, restarted

  typedef struct packed {
    logic mask;
    logic step;
    logic halt;
    logic en;
  } ctrl_t;

  typedef enum logic {ST_IDLE, ST_STEP} step_st_e;
endpackage

// File: rtl/dhcs_ctrl.sv
module dhcs_ctrl
  import dhcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ok_i,
  input  logic              src_core_i,
  input  logic [CTRL_W-1:0] wbits_i,
  input  logic              sys_rst_i,
  input  logic              halted_i,
  input  logic              retire_i,
  output ctrl_t             ctrl_o,
  output logic              halt_req_o,
  output logic              step_req_o
);
  ctrl_t    ctrl_q;
  step_st_e st_q;
  logic     en_next;

  assign en_next = src_core_i ? ctrl_q.en : wbits_i[B_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      st_q   <= ST_IDLE;
    end else if (sys_rst_i) begin
      ctrl_q.halt <= 1'b0;
      st_q        <= ST_IDLE;
    end else if (wr_ok_i) begin
      ctrl_q.en   <= en_next;
      ctrl_q.halt <= wbits_i[B_HALT];
      ctrl_q.step <= wbits_i[B_STEP];
      if (ctrl_q.halt && wbits_i[B_HALT]) ctrl_q.mask <= wbits_i[B_MASK];
      if (en_next && wbits_i[B_STEP] && !wbits_i[B_HALT] && halted_i) st_q <= ST_STEP;
      else                                                          st_q <= ST_IDLE;
    end else if (st_q == ST_STEP && retire_i) begin
      ctrl_q.halt <= 1'b1;
      st_q        <= ST_IDLE;
    end
  end

  // re-request halt in the retire cycle so only one instruction completes
  assign halt_req_o = ctrl_q.en && (ctrl_q.halt || (st_q == ST_STEP && retire_i));
  assign step_req_o = ctrl_q.en && (st_q == ST_STEP);
  assign ctrl_o     = ctrl_q;
endmodule

// File: rtl/dhcs_status.sv
module dhcs_status
  import dhcs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_clr_i,
  input  logic              sys_rst_i,
  input  logic              retire_i,
  input  logic              halted_i,
  input  logic              lockup_i,
  input  logic              sleeping_i,
  input  logic              xfer_start_i,
  input  logic              xfer_done_i,
  output logic [DATA_W-1:0] stat_o
);
  logic                rdy_q, lock_q, halted_d;
  logic [N_STICKY-1:0] ev, sticky_q;

  assign ev = {halted_d && !halted_i, sys_rst_i, retire_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q    <= 1'b0;
      lock_q   <= 1'b0;
      halted_d <= 1'b0;
    end else begin
      halted_d <= halted_i;
      if (xfer_done_i)       rdy_q <= 1'b1;
      else if (xfer_start_i) rdy_q <= 1'b0;
      if (halted_i)          lock_q <= 1'b0;
      else if (lockup_i)     lock_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    // set wins over read-clear so an event during a read is not lost
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    sticky_q[g] <= 1'b0;
      else if (ev[g]) sticky_q[g] <= 1'b1;
      else if (rd_clr_i) sticky_q[g] <= 1'b0;
    end
  end

  always_comb begin
    stat_o = '0;
    stat_o[B_RDY]  = rdy_q;
    stat_o[B_HLTD] = halted_i;
    stat_o[B_SLP]  = sleeping_i;
    stat_o[B_LOCK] = lock_q;
    stat_o[B_STICKY +: N_STICKY] = sticky_q;
  end
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dhcs_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'hF0,
  parameter logic [15:0]       KEY_VAL  = 16'hA05F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              src_core_i,
  output logic [31:0]       rdata_o,
  output logic              halt_req_o,
  output logic              step_req_o,
  input  logic              halted_i,
  input  logic              retire_i,
  input  logic              core_reset_i,
  input  logic              lockup_i,
  input  logic              sleeping_i,
  input  logic              xfer_start_i,
  input  logic              xfer_done_i
);
  logic              hit, wr_ok, rd_clr;
  ctrl_t             ctrl;
  logic [DATA_W-1:0] stat, reg_w;

  assign hit    = (addr_i == REG_ADDR);
  assign wr_ok  = we_i && hit && (wdata_i[KEY_LSB +: KEY_W] == KEY_VAL);
  assign rd_clr = re_i && hit;

  dhcs_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_ok_i    (wr_ok),
    .src_core_i (src_core_i),
    .wbits_i    (wdata_i[CTRL_W-1:0]),
    .sys_rst_i  (core_reset_i),
    .halted_i   (halted_i),
    .retire_i   (retire_i),
    .ctrl_o     (ctrl),
    .halt_req_o (halt_req_o),
    .step_req_o (step_req_o)
  );

  dhcs_status u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_clr_i     (rd_clr),
    .sys_rst_i    (core_reset_i),
    .retire_i     (retire_i),
    .halted_i     (halted_i),
    .lockup_i     (lockup_i),
    .sleeping_i   (sleeping_i),
    .xfer_start_i (xfer_start_i),
    .xfer_done_i  (xfer_done_i),
    .stat_o       (stat)
  );

  assign reg_w   = stat | {{(DATA_W-CTRL_W){1'b0}}, ctrl};
  assign rdata_o = rd_clr ? reg_w : '0;
endmodule

// File: rtl/dhcs_chk.sv
module dhcs_chk #(
  parameter logic [15:0] KEY_VAL = 16'hA05F
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        hit,
  input logic        we_i,
  input logic        wr_ok,
  input logic        src_core_i,
  input logic [31:0] wdata_i,
  input logic        core_reset_i,
  input logic        halted_i,
  input logic        retire_i,
  input logic        xfer_start_i,
  input logic        xfer_done_i,
  input logic        halt_req_o,
  input logic        step_req_o,
  input logic [31:0] reg_w
);
  assert_bad_key_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && hit && wdata_i[31:16] != KEY_VAL && !core_reset_i && !retire_i)
      |=> reg_w[3:0] == $past(reg_w[3:0]));

  assert_retire_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |=> reg_w[24]);

  assert_lock_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_i |=> !reg_w[19]);

  assert_rdy_set_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_i |=> reg_w[16]);

  assert_rdy_clr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_start_i && !xfer_done_i) |=> !reg_w[16]);

  assert_core_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_reset_i |=> !reg_w[1] && reg_w[25] && reg_w[0] == $past(reg_w[0]));

  assert_step_from_halt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(step_req_o) |-> $past(halted_i));

  assert_core_no_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && src_core_i) |=> $stable(reg_w[0]));

  assert_no_req_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_w[0] |-> !halt_req_o && !step_req_o);

  assert_mask_rule_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(reg_w[3]) |-> $past(wr_ok) && $past(reg_w[1]) && $past(wdata_i[1]));
endmodule

bind dbg_halt_ctrl dhcs_chk #(.KEY_VAL(KEY_VAL)) u_dhcs_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .hit          (hit),
  .we_i         (we_i),
  .wr_ok        (wr_ok),
  .src_core_i   (src_core_i),
  .wdata_i      (wdata_i),
  .core_reset_i (core_reset_i),
  .halted_i     (halted_i),
  .retire_i     (retire_i),
  .xfer_start_i (xfer_start_i),
  .xfer_done_i  (xfer_done_i),
  .halt_req_o   (halt_req_o),
  .step_req_o   (step_req_o),
  .reg_w        (reg_w)
);

// File: tb/test_dbg_halt_ctrl.sv
`timescale 1ns/1ps
module test_dbg_halt_ctrl;
  localparam logic [7:0]  RA  = 8'hF0;
  localparam logic [15:0] KEY = 16'hA05F;

  logic        clk = 0, rst_n = 0;
  logic [7:0]  addr = RA;
  logic [31:0] wdata = 0, rdata;
  logic        we = 0, re = 0, src_core = 0, core_reset = 0;
  logic        halted_q = 0, retire, lockup = 0, sleeping = 0, xs = 0, xd = 0;
  logic        halt_req, step_req, freeze = 1, pulse_ret = 0;
  int          n_chk = 0, n_fail = 0, rcnt = 0;

  always #2.5 clk = ~clk;

  assign retire = freeze ? pulse_ret : !halted_q;
  always @(posedge clk) begin
    if (!freeze) halted_q <= halt_req;
    if (retire) rcnt <= rcnt + 1;
  end

  dbg_halt_ctrl i_dbg_halt_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we), .re_i(re),
    .src_core_i(src_core), .rdata_o(rdata), .halt_req_o(halt_req), .step_req_o(step_req),
    .halted_i(halted_q), .retire_i(retire), .core_reset_i(core_reset), .lockup_i(lockup),
    .sleeping_i(sleeping), .xfer_start_i(xs), .xfer_done_i(xd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] key, input logic [3:0] bits, input logic core);
    @(negedge clk);
    we = 1; src_core = core; wdata = {key, 12'h0, bits};
    @(negedge clk);
    we = 0; src_core = 0; wdata = 0;
  endtask

  task automatic rd(output logic [31:0] v);
    @(negedge clk);
    re = 1;
    #1 v = rdata;
    @(negedge clk);
    re = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, base;
    logic [3:0]  m;
    int          c0;
    idle(3);
    rst_n = 1;
    idle(2);
    // R6 power-on state
    rd(v);
    chk("R6 reset word", v, 32'h0);

    // R10/R2 sweep of all consecutive control pairs, core frozen running
    m = 0;
    for (int p = 0; p < 16; p++) begin
      for (int n = 0; n < 16; n++) begin
        wr(KEY, p[3:0], 0);
        m = {((m[1] && p[1]) ? p[3] : m[3]), p[2:0]};
        wr(KEY, n[3:0], 0);
        m = {((m[1] && n[1]) ? n[3] : m[3]), n[2:0]};
        rd(v);
        chk("R10 ctrl after pair", {28'h0, v[3:0]}, {28'h0, m});
        chk("R2 zero fields", v & 32'hF8F0_FFF0, 32'h0);
      end
    end

    // R1 key sweep
    wr(KEY, 4'h3, 0);
    rd(base);
    for (int b = 0; b < 16; b++) begin
      wr(KEY ^ (16'h1 << b), 4'hC, 0);
      rd(v);
      chk("R1 bad key ignored", {28'h0, v[3:0]}, {28'h0, base[3:0]});
    end
    wr(16'h0000, 4'h0, 0);
    rd(v);
    chk("R1 zero key ignored", {28'h0, v[3:0]}, {28'h0, base[3:0]});

    // R8 core-side write keeps debug enable
    wr(KEY, 4'h0, 1);
    rd(v);
    chk("R8 core write en kept", {28'h0, v[3:0]}, 32'h1);
    wr(KEY, 4'h0, 0);
    rd(v);
    chk("R8 debug port clears en", {31'h0, v[0]}, 32'h0);

    // R3 sticky retire
    rd(v);
    pulse(pulse_ret);
    rd(v);
    chk("R3 retire set", {31'h0, v[24]}, 32'h1);
    rd(v);
    chk("R3 retire cleared by read", {31'h0, v[24]}, 32'h0);
    @(negedge clk); re = 1; pulse_ret = 1;
    #1 v = rdata;
    @(negedge clk); re = 0; pulse_ret = 0;
    chk("R3 read during event sees old", {31'h0, v[24]}, 32'h0);
    rd(v);
    chk("R3 event during read kept", {31'h0, v[24]}, 32'h1);

    // R5 transfer ready handshake
    pulse(xd);
    rd(v);
    chk("R5 done sets ready", {31'h0, v[16]}, 32'h1);
    pulse(xs);
    rd(v);
    chk("R5 start clears ready", {31'h0, v[16]}, 32'h0);

    // R4 lockup, R2 sleeping live
    pulse(lockup);
    rd(v);
    chk("R4 lockup set", {31'h0, v[19]}, 32'h1);
    sleeping = 1;
    rd(v);
    chk("R2 sleeping live", {31'h0, v[18]}, 32'h1);
    sleeping = 0;

    // R9 halt bit without debug enable
    freeze = 0;
    wr(KEY, 4'h2, 0);
    idle(6);
    rd(v);
    chk("R9 no halt when disabled", {30'h0, v[17], halt_req}, 32'h0);
    chk("R4 lockup held while running", {31'h0, v[19]}, 32'h1);

    // halt
    wr(KEY, 4'h3, 0);
    idle(4);
    rd(v);
    chk("R2 halted live", {31'h0, v[17]}, 32'h1);
    chk("R4 lockup cleared on halt", {31'h0, v[19]}, 32'h0);
    rd(v);

    // R7 single step, plain and with mask attempt
    for (int k = 0; k < 2; k++) begin
      c0 = rcnt;
      wr(KEY, (k == 0) ? 4'h5 : 4'hD, 0);
      idle(8);
      chk("R7 one instruction per step", rcnt - c0, 32'h1);
      rd(v);
      chk("R7 halted after step", {30'h0, v[17], v[1]}, 32'h3);
      chk("R3 restart sticky after step", {31'h0, v[26]}, 32'h1);
      chk("R10 mask unchanged by step", {31'h0, v[3]}, 32'h0);
    end

    // R9 step with debug disabled does nothing to a halted core
    wr(KEY, 4'h1, 0);
    idle(4);
    wr(KEY, 4'h3, 0);
    idle(4);
    rd(v);
    c0 = rcnt;
    wr(KEY, 4'h4, 0);
    idle(6);
    chk("R9 disabled: halt request low", {31'h0, halt_req}, 32'h0);
    wr(KEY, 4'h3, 0);
    idle(4);

    // R6 core reset keeps enable, clears halt
    rd(v);
    pulse(core_reset);
    idle(4);
    rd(v);
    chk("R6 core reset: en kept, halt cleared", {28'h0, v[3:0]} & 32'h3, 32'h1);
    chk("R3 reset sticky", {31'h0, v[25]}, 32'h1);
    chk("R6 core runs after reset", {31'h0, v[17]}, 32'h0);
    rd(v);
    chk("R3 reset sticky cleared", {31'h0, v[25]}, 32'h0);

    finish_run();
  end
endmodule